// File: doc/BRIEF.md
# Eight-Channel Volume and Automatic Mute Stage

This block is the gain stage of a multichannel audio path. Every time the sample strobe is high it takes one signed 24-bit sample for each of eight channels, works out one attenuation for each channel from a shared master code and that channel's own code, scales the sample and registers the result. All codes are in 0.5 dB steps. The master code is added to every channel code, and a channel code of zero means the channel adds no attenuation. A force input pins the master code to zero (full scale) whatever value the master code input carries.

Volume changes can be smoothed in two ways. Each can be used alone or with the other. With zero-crossing gating, a new attenuation is taken up only on a sample that is zero or whose sign differs from the previous sample of the same channel. With soft ramping, the effective attenuation walks toward the target by one 0.5 dB code per strobe. A master mute silences every channel, and a per-channel mute silences one channel. When zero detection is enabled, a channel that has seen 2048 consecutive zero samples flags itself as automatically muted, and it releases on its first non-zero sample. All settings arrive as parallel inputs from a register block outside this one.

Top module: `mcv_volume_mute`

## Requirements
- R1: For a total attenuation code a, the gain is g = round(32768 * 2^(-(a mod 12)/12)) shifted right by floor(a/12). Each output is floor(sample * g / 32768), clamped to the signed 24-bit range. A total code of 255 gives an output of exactly zero.
- R2: The total code is the master code plus the channel code, saturated at 255. When master_force_i is high, the master code counts as 0.
- R3: With zero-crossing gating and soft ramping both off, a new total code is used for the sample of the same strobe that first sees it.
- R4: With zero-crossing gating on, the effective code changes only on a strobe whose sample is zero or whose sign bit differs from the previous strobe's sample on that channel. On every other strobe the previous effective code is kept.
- R5: With soft ramping on, the effective code moves one step toward the target on each strobe and stops at the target.
- R6: With zero detection on, bit c of auto_mute_o goes high in the cycle after the 2048th consecutive zero sample on channel c, and not after the 2047th.
- R7: A non-zero sample on channel c clears auto_mute_o[c] in the following cycle and restarts the zero count, so another 2048 zeros are needed to set it again.
- R8: While zdet_en_i is low, auto_mute_o is all zero from the next cycle on.
- R9: master_mute_i forces every channel's output for that strobe to zero. ch_mute_i[c] forces channel c alone to zero.
- R10: smp_valid_o is high exactly in the cycle after a strobe. smp_o changes only in that cycle and holds its value between strobes.
- R11: After reset, smp_o, smp_valid_o and auto_mute_o are zero, and every channel's effective code is 255. With gating on, a first positive sample therefore comes out as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid_i | input | 1 | Sample strobe, one cycle per sample period |
| smp_i | input | 192 | Eight signed 24-bit samples, channel c at bits c*24 up |
| master_att_i | input | 8 | Master attenuation code, 0.5 dB per step |
| master_force_i | input | 1 | Forces master code to zero |
| ch_att_i | input | 64 | Eight channel attenuation codes, channel c at bits c*8 up |
| master_mute_i | input | 1 | Silences all channels |
| ch_mute_i | input | 8 | Per-channel mute |
| zc_en_i | input | 1 | Zero-crossing gating enable |
| soft_en_i | input | 1 | Soft ramping enable |
| zdet_en_i | input | 1 | Zero-detect automatic mute enable |
| smp_valid_o | output | 1 | Output sample strobe |
| smp_o | output | 192 | Eight scaled signed 24-bit samples |
| auto_mute_o | output | 8 | Per-channel automatic mute flags |

## Verification
The bench goes after the attenuation boundaries: a sum that saturates at the mute code, a code of 254 whose shift removes all bits, the most negative input sample, and negative products where a rounding floor error would show as an off-by-one. It checks the zero-run length on both sides of 2048. A counter that is off by one would set the flag one strobe early or late, and a counter that failed to restart after release would set it again too soon. Zero-crossing gating is checked first with no crossing, where a design that applies the change anyway scales the sample, and then at a zero sample. The reset mute code is checked through a first positive sample that must come out as zero. Soft ramping is checked at every step, including the stop at the target and the reversal.

// File: rtl/mcv_pkg.sv
package mcv_pkg;
  localparam int GAIN_FRAC     = 15;
  localparam int GAIN_W        = GAIN_FRAC + 1;
  localparam int STEPS_PER_6DB = 12;

  // Q1.15 mantissa for one twelfth-of-an-octave step: round(2^15 * 2^(-r/12))
  function automatic logic [GAIN_W-1:0] step_mantissa(input logic [3:0] r);
    case (r)
      4'd0:    return 16'd32768;
      4'd1:    return 16'd30929;
      4'd2:    return 16'd29193;
      4'd3:    return 16'd27554;
      4'd4:    return 16'd26008;
      4'd5:    return 16'd24548;
      4'd6:    return 16'd23170;
      4'd7:    return 16'd21870;
      4'd8:    return 16'd20643;
      4'd9:    return 16'd19484;
      4'd10:   return 16'd18390;
      4'd11:   return 16'd17358;
      default: return 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/mcv_gain_lut.sv
module mcv_gain_lut
  import mcv_pkg::*;
#(
  parameter int ATT_W = 8
) (
  input  logic [ATT_W-1:0]  att_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam logic [ATT_W-1:0] MUTE_ATT = '1;
  localparam logic [ATT_W-1:0] STEPS    = ATT_W'(STEPS_PER_6DB);

  logic [ATT_W-1:0] octave;
  logic [3:0]       frac;

  always_comb begin
    octave = att_i / STEPS;
    frac   = 4'(att_i % STEPS);
    if (att_i == MUTE_ATT) gain_o = '0;
    else                   gain_o = step_mantissa(frac) >> octave;
  end
endmodule

// File: rtl/mcv_zero_watch.sv
module mcv_zero_watch #(
  parameter int ZRUN = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic vld_i,
  input  logic zero_i,
  output logic mute_o
);
  localparam int CW = $clog2(ZRUN + 1);
  localparam logic [CW-1:0] LAST = CW'(ZRUN - 1);
  localparam logic [CW-1:0] FULL = CW'(ZRUN);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      run_cnt <= '0;
      mute_o  <= 1'b0;
    end else if (vld_i) begin
      if (zero_i) begin
        if (run_cnt != FULL) run_cnt <= run_cnt + 1'b1;
        if (run_cnt == LAST) mute_o  <= 1'b1;
      end else begin
        run_cnt <= '0;
        mute_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mcv_chan.sv
module mcv_chan
  import mcv_pkg::*;
#(
  parameter int DW    = 24,
  parameter int ATT_W = 8,
  parameter int ZRUN  = 2048
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] smp_i,
  input  logic [ATT_W-1:0]     tgt_i,
  input  logic                 zc_en_i,
  input  logic                 soft_en_i,
  input  logic                 zdet_en_i,
  input  logic                 mute_i,
  output logic signed [DW-1:0] smp_o,
  output logic                 zmute_o
);
  localparam int PW = DW + GAIN_W + 1;
  localparam logic [ATT_W-1:0]    MUTE_ATT = '1;
  localparam logic signed [PW-1:0] S_MAX = (PW'(1) <<< (DW - 1)) - PW'(1);
  localparam logic signed [PW-1:0] S_MIN = ~S_MAX;

  logic [ATT_W-1:0]     cur_att, step_att, nxt_att;
  logic                 prev_neg, crossing, is_zero;
  logic [GAIN_W-1:0]    gain;
  logic signed [PW-1:0] prod, scaled;
  logic signed [DW-1:0] clamped;

  assign is_zero = (smp_i == '0);

  always_comb begin
    crossing = is_zero || (smp_i[DW-1] != prev_neg);
    if (!soft_en_i)            step_att = tgt_i;
    else if (cur_att < tgt_i)  step_att = cur_att + 1'b1;
    else if (cur_att > tgt_i)  step_att = cur_att - 1'b1;
    else                       step_att = cur_att;
    nxt_att = (!zc_en_i || crossing) ? step_att : cur_att;
  end

  mcv_gain_lut #(.ATT_W(ATT_W)) u_lut (
    .att_i (nxt_att),
    .gain_o(gain)
  );

  always_comb begin
    prod   = PW'(smp_i) * PW'($signed({1'b0, gain}));
    scaled = prod >>> GAIN_FRAC;
    if (scaled > S_MAX)      clamped = S_MAX[DW-1:0];
    else if (scaled < S_MIN) clamped = S_MIN[DW-1:0];
    else                     clamped = scaled[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_att  <= MUTE_ATT;
      prev_neg <= 1'b0;
      smp_o    <= '0;
    end else if (vld_i) begin
      cur_att  <= nxt_att;
      prev_neg <= smp_i[DW-1];
      smp_o    <= mute_i ? '0 : clamped;
    end
  end

  mcv_zero_watch #(.ZRUN(ZRUN)) u_zw (
    .clk   (clk),
    .rst   (rst),
    .en_i  (zdet_en_i),
    .vld_i (vld_i),
    .zero_i(is_zero),
    .mute_o(zmute_o)
  );
endmodule

// File: rtl/mcv_volume_mute.sv
module mcv_volume_mute #(
  parameter int NCH   = 8,
  parameter int DW    = 24,
  parameter int ATT_W = 8,
  parameter int ZRUN  = 2048
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid_i,
  input  logic [NCH*DW-1:0]    smp_i,
  input  logic [ATT_W-1:0]     master_att_i,
  input  logic                 master_force_i,
  input  logic [NCH*ATT_W-1:0] ch_att_i,
  input  logic                 master_mute_i,
  input  logic [NCH-1:0]       ch_mute_i,
  input  logic                 zc_en_i,
  input  logic                 soft_en_i,
  input  logic                 zdet_en_i,
  output logic                 smp_valid_o,
  output logic [NCH*DW-1:0]    smp_o,
  output logic [NCH-1:0]       auto_mute_o
);
  localparam logic [ATT_W:0] MUTE_SUM = {1'b0, {ATT_W{1'b1}}};

  logic [ATT_W-1:0] master_eff;
  assign master_eff = master_force_i ? '0 : master_att_i;

  always_ff @(posedge clk) begin
    if (rst) smp_valid_o <= 1'b0;
    else     smp_valid_o <= smp_valid_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [ATT_W:0]   sum;
    logic [ATT_W-1:0] tgt;
    logic signed [DW-1:0] out_c;

    assign sum = {1'b0, master_eff} + {1'b0, ch_att_i[c*ATT_W +: ATT_W]};
    assign tgt = (sum >= MUTE_SUM) ? MUTE_SUM[ATT_W-1:0] : sum[ATT_W-1:0];

    mcv_chan #(.DW(DW), .ATT_W(ATT_W), .ZRUN(ZRUN)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .vld_i    (smp_valid_i),
      .smp_i    ($signed(smp_i[c*DW +: DW])),
      .tgt_i    (tgt),
      .zc_en_i  (zc_en_i),
      .soft_en_i(soft_en_i),
      .zdet_en_i(zdet_en_i),
      .mute_i   (master_mute_i | ch_mute_i[c]),
      .smp_o    (out_c),
      .zmute_o  (auto_mute_o[c])
    );
    assign smp_o[c*DW +: DW] = out_c;
  end
endmodule

// File: rtl/mcv_chk.sv
module mcv_chk #(
  parameter int NCH   = 8,
  parameter int DW    = 24,
  parameter int ATT_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 smp_valid_i,
  input logic [NCH*DW-1:0]    smp_i,
  input logic                 master_mute_i,
  input logic [NCH-1:0]       ch_mute_i,
  input logic                 zdet_en_i,
  input logic                 smp_valid_o,
  input logic [NCH*DW-1:0]    smp_o,
  input logic [NCH-1:0]       auto_mute_o
);
  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst) smp_valid_i |=> smp_valid_o); // R10
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst) !smp_valid_i |=> !smp_valid_o); // R10
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) !smp_valid_i |=> $stable(smp_o)); // R10
  AST_MASTER_MUTE: assert property (@(posedge clk) disable iff (rst) (smp_valid_i && master_mute_i) |=> (smp_o == '0)); // R9
  AST_ZDET_OFF: assert property (@(posedge clk) disable iff (rst) !zdet_en_i |=> (auto_mute_o == '0)); // R8

  for (genvar c = 0; c < NCH; c++) begin : g_ch_chk
    AST_CH_MUTE: assert property (@(posedge clk) disable iff (rst) (smp_valid_i && ch_mute_i[c]) |=> (smp_o[c*DW +: DW] == '0)); // R9
    AST_AUTO_RELEASE: assert property (@(posedge clk) disable iff (rst) (smp_valid_i && smp_i[c*DW +: DW] != '0) |=> !auto_mute_o[c]); // R7
    AST_ZERO_IN_OUT: assert property (@(posedge clk) disable iff (rst) (smp_valid_i && smp_i[c*DW +: DW] == '0) |=> (smp_o[c*DW +: DW] == '0)); // R1
    AST_AUTO_RISE: assert property (@(posedge clk) disable iff (rst) $rose(auto_mute_o[c]) |-> $past(smp_valid_i)); // R6
  end
endmodule

bind mcv_volume_mute mcv_chk #(.NCH(NCH), .DW(DW), .ATT_W(ATT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .smp_valid_i  (smp_valid_i),
  .smp_i        (smp_i),
  .master_mute_i(master_mute_i),
  .ch_mute_i    (ch_mute_i),
  .zdet_en_i    (zdet_en_i),
  .smp_valid_o  (smp_valid_o),
  .smp_o        (smp_o),
  .auto_mute_o  (auto_mute_o)
);

// File: tb/mcv_volume_mute_tb.sv
module mcv_volume_mute_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int DW  = 24;

  typedef struct packed {
    logic [7:0]         m;
    logic [7:0]         ca;
    logic               f;
    logic signed [23:0] s;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{8'd0,   8'd0,   1'b0, 24'sd100000},
    '{8'd12,  8'd0,   1'b0, -24'sd100000},
    '{8'd6,   8'd6,   1'b0, 24'sd123457},
    '{8'd200, 8'd100, 1'b0, 24'sd5000},
    '{8'd100, 8'd50,  1'b1, 24'sd777777},
    '{8'd0,   8'd248, 1'b0, 24'sd8388607},
    '{8'd5,   8'd0,   1'b0, -24'sd8388608},
    '{8'd24,  8'd11,  1'b0, -24'sd3}
  };

  logic clk = 0, rst = 1;
  logic smp_valid_i = 0;
  logic [NCH*DW-1:0] smp_i;
  logic [7:0] master_att_i = 0;
  logic master_force_i = 0;
  logic [NCH*8-1:0] ch_att_i = '0;
  logic master_mute_i = 0;
  logic [NCH-1:0] ch_mute_i = '0;
  logic zc_en_i = 1, soft_en_i = 0, zdet_en_i = 0;
  logic smp_valid_o;
  logic [NCH*DW-1:0] smp_o;
  logic [NCH-1:0] auto_mute_o;

  logic signed [DW-1:0] tb_s [NCH];
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int c = 0; c < NCH; c++) smp_i[c*DW +: DW] = tb_s[c];

  mcv_volume_mute u_dut (
    .clk(clk), .rst(rst), .smp_valid_i(smp_valid_i), .smp_i(smp_i),
    .master_att_i(master_att_i), .master_force_i(master_force_i),
    .ch_att_i(ch_att_i), .master_mute_i(master_mute_i), .ch_mute_i(ch_mute_i),
    .zc_en_i(zc_en_i), .soft_en_i(soft_en_i), .zdet_en_i(zdet_en_i),
    .smp_valid_o(smp_valid_o), .smp_o(smp_o), .auto_mute_o(auto_mute_o)
  );

  function automatic longint exp_out(longint s, int att);
    longint mant, g, p;
    int r, q;
    if (att >= 255) return 0;
    r = att % 12;
    q = att / 12;
    mant = longint'($rtoi(32768.0 * (2.0 ** (-r / 12.0)) + 0.5));
    g = mant >> q;
    p = (s * g) >>> 15;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return p;
  endfunction

  function automatic longint out_ch(int c);
    return longint'($signed(smp_o[c*DW +: DW]));
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk);
    smp_valid_i = 1;
    @(negedge clk);
    smp_valid_i = 0;
  endtask

  task automatic set_all(longint v);
    for (int c = 0; c < NCH; c++) tb_s[c] = DW'(v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    set_all(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11 reset smp_o", longint'(smp_o == '0), 1);
    chk("R11 reset valid", longint'(smp_valid_o), 0);
    chk("R11 reset auto_mute", longint'(auto_mute_o), 0);

    // R11: effective code is mute after reset; positive sample with gating is no crossing
    set_all(1000);
    strobe();
    chk("R11 first sample muted ch0", out_ch(0), 0);
    chk("R11 first sample muted ch7", out_ch(7), 0);
    // R4: sign change is a crossing, code 0 taken up
    set_all(-1000);
    strobe();
    chk("R4 crossing applies ch0", out_ch(0), -1000);
    chk("R4 crossing applies ch5", out_ch(5), -1000);

    // Vector table: immediate mode, R1 R2 R3
    zc_en_i = 0;
    for (int v = 0; v < NVEC; v++) begin
      master_att_i = VECS[v].m;
      master_force_i = VECS[v].f;
      for (int c = 0; c < NCH; c++) begin
        ch_att_i[c*8 +: 8] = 8'(VECS[v].ca + 8'(c));
        tb_s[c] = VECS[v].s >>> c;
      end
      strobe();
      for (int c = 0; c < NCH; c++) begin
        int tot;
        tot = (VECS[v].f ? 0 : int'(VECS[v].m)) + int'(8'(VECS[v].ca + 8'(c)));
        if (tot > 255) tot = 255;
        chk($sformatf("R1/R2/R3 vec%0d ch%0d att%0d", v, c, tot), out_ch(c),
            exp_out(longint'(tb_s[c]), tot));
      end
    end

    // R4 zero-crossing gating
    master_att_i = 0; master_force_i = 0; ch_att_i = '0;
    set_all(500);
    strobe();
    chk("R4 setup ch0", out_ch(0), 500);
    zc_en_i = 1;
    master_att_i = 12;
    set_all(2000);
    strobe();
    chk("R4 no crossing keeps old gain", out_ch(0), 2000);
    set_all(0);
    strobe();
    chk("R4 zero sample output", out_ch(0), 0);
    set_all(2000);
    strobe();
    chk("R4 new gain after zero", out_ch(0), 1000);
    chk("R4 new gain after zero ch6", out_ch(6), 1000);

    // R5 soft ramp
    zc_en_i = 0;
    master_att_i = 0;
    set_all(32768);
    strobe();
    chk("R5 setup", out_ch(0), 32768);
    soft_en_i = 1;
    master_att_i = 3;
    strobe();
    chk("R5 step 1", out_ch(0), exp_out(32768, 1));
    strobe();
    chk("R5 step 2", out_ch(0), exp_out(32768, 2));
    strobe();
    chk("R5 step 3", out_ch(3), exp_out(32768, 3));
    strobe();
    chk("R5 stops at target", out_ch(0), exp_out(32768, 3));
    master_att_i = 0;
    strobe();
    chk("R5 reverse step", out_ch(0), exp_out(32768, 2));

    // R10 hold between strobes
    chk("R10 valid_o after strobe", longint'(smp_valid_o), 1);
    set_all(5);
    master_att_i = 40;
    repeat (3) @(negedge clk);
    chk("R10 valid_o idle", longint'(smp_valid_o), 0);
    chk("R10 smp_o held", out_ch(0), exp_out(32768, 2));

    // R9 mutes
    soft_en_i = 0;
    master_att_i = 0;
    set_all(1000);
    strobe();
    chk("R9 setup", out_ch(2), 1000);
    ch_mute_i = 8'h04;
    strobe();
    chk("R9 channel mute ch2", out_ch(2), 0);
    chk("R9 channel mute leaves ch3", out_ch(3), 1000);
    ch_mute_i = '0;
    master_mute_i = 1;
    strobe();
    chk("R9 master mute ch0", out_ch(0), 0);
    chk("R9 master mute ch5", out_ch(5), 0);
    master_mute_i = 0;

    // R6 zero detect
    zdet_en_i = 1;
    set_all(0);
    repeat (2047) strobe();
    chk("R6 no flag after 2047 zeros", longint'(auto_mute_o), 0);
    strobe();
    chk("R6 flag after 2048 zeros", longint'(auto_mute_o), 255);

    // R7 release and restart
    tb_s[0] = 24'sd100;
    strobe();
    chk("R7 release ch0", longint'(auto_mute_o), 254);
    chk("R7 released sample passes", out_ch(0), 100);
    tb_s[0] = 0;
    repeat (2047) strobe();
    chk("R7 restart needs full run", longint'(auto_mute_o), 254);
    strobe();
    chk("R7 flag again after 2048", longint'(auto_mute_o), 255);

    // R8 disable clears
    @(negedge clk);
    zdet_en_i = 0;
    @(negedge clk);
    chk("R8 disable clears flags", longint'(auto_mute_o), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule